// File: doc/BRIEF.md
# Control Register Port with Write-Triggered Datapath Reset

This block holds the two 10-bit configuration words of a dual FIR filter datapath and breaks them out into named fields. A host loads a word by placing a 9-bit address and a 10-bit value on its buses and raising a write strobe. The strobe has no timing relationship to the processing clock. The value is captured on the strobe's rising edge into a host-side register.

Each accepted write flips a toggle flag. The flag crosses into the processing clock domain through a two-stage synchronizer. An edge detector there turns it into a single-cycle event. That event copies both host-side words into clock-domain shadow registers, which drive the field outputs. The same event also starts a datapath reset output that lasts six clock cycles. This reset is meant for the filter pipeline only; coefficient storage does not use it.

A further write that arrives while the reset is active restarts the six-cycle count. Writes to any address other than the two register addresses have no effect. A synchronous power-on reset clears both words.

Top module: `cfg_port`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, every field output is 0 and `dp_reset` is low.
- R2: A write to address 0 captures `host_data` as word 0. Its fields are decoded as follows: `decim_code` is bits 3:0, and a value n means decimate by n+1 with a delay length of n+1. `dual_mode` is bit 4, `odd_sym` bit 5, `a_even_taps` bit 6, `b_even_taps` bit 7, `b_src_sel` bit 8 (1 = second input) and `interleave` bit 9.
- R3: A write to address 1 captures word 1. Its fields are decoded as follows: `a_in_fmt` is bit 0, `a_coef_fmt` bit 1, `b_in_fmt` bit 2, `b_coef_fmt` bit 3, `reverse_en` bit 4, `round_pos` bits 8:5 and `round_en` bit 9.
- R4: A write to any address other than 0 or 1, including the reserved range 0x002 to 0x0FF, changes neither word and produces no datapath reset.
- R5: Every write to address 0 or 1 drives `dp_reset` high for exactly 6 consecutive clock cycles.
- R6: When the strobe rises more than a setup time before a clock edge, `dp_reset` and the new field values appear at the third rising clock edge after the strobe's rising edge.
- R7: A valid write whose event arrives while `dp_reset` is high restarts the count, so `dp_reset` stays high until 6 cycles after that later event.
- R8: Field outputs change only at the edge that starts a datapath reset. A write to one word leaves the other word's fields unchanged.
- R9: Data is taken at the strobe's rising edge. A change on `host_data` while the strobe stays high does not affect the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Power-on reset, active high, synchronous to clk (also clears the host-side words) |
| host_addr | input | 9 | Register address |
| host_data | input | 10 | Write data |
| host_wr | input | 1 | Write strobe, data taken on rising edge |
| dp_reset | output | 1 | Datapath reset, excludes coefficient storage |
| decim_code | output | 4 | Decimation code |
| dual_mode | output | 1 | Two independent filters when 1 |
| odd_sym | output | 1 | Odd-symmetric coefficients when 1 |
| a_even_taps | output | 1 | Filter A has an even tap count |
| b_even_taps | output | 1 | Filter B has an even tap count |
| b_src_sel | output | 1 | Filter B input source select |
| interleave | output | 1 | Interleaved coefficient sets |
| a_in_fmt | output | 1 | Filter A input data format |
| a_coef_fmt | output | 1 | Filter A coefficient format |
| b_in_fmt | output | 1 | Filter B input data format |
| b_coef_fmt | output | 1 | Filter B coefficient format |
| reverse_en | output | 1 | Data reversal enable |
| round_pos | output | 4 | Rounding position |
| round_en | output | 1 | Output rounding enable |

## Verification
The bench raises the strobe on a falling clock edge. The first rising edge after that loads the first synchronizer stage, and the second rising edge produces the event. The field outputs and `dp_reset` are therefore due after the third rising edge. `dp_reset` must then read high on that falling edge and the five after it, then low.

Every observation is taken on a falling edge, counted from the strobe. The bench checks three things at known offsets: the index of the first high sample, the number of high samples, and that the fields are still unchanged one edge before the load. For the restart case the second strobe comes five falling edges after the first. `dp_reset` is then expected to stay high from offset 3 through offset 13.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_W    = 10;
  localparam int ADDR_W   = 9;
  localparam int NUM_REGS = 2;

  typedef struct packed {
    logic       interleave;
    logic       b_src_sel;
    logic       b_even_taps;
    logic       a_even_taps;
    logic       odd_sym;
    logic       dual_mode;
    logic [3:0] decim_code;
  } word0_t;

  typedef struct packed {
    logic       round_en;
    logic [3:0] round_pos;
    logic       reverse_en;
    logic       b_coef_fmt;
    logic       b_in_fmt;
    logic       a_coef_fmt;
    logic       a_in_fmt;
  } word1_t;
endpackage

// File: rtl/cfgw_capture.sv
// Host-domain capture: one word per register address plus a toggle that
// flips on every accepted write. Clocked by the write strobe itself.
module cfgw_capture #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 10,
  parameter int NUM_REGS = 2
) (
  input  logic                       host_wr,
  input  logic                       clr,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic [DATA_W-1:0]          host_data,
  output logic [NUM_REGS*DATA_W-1:0] words,
  output logic                       wr_tgl
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic hit_any;
  assign hit_any = (host_addr <= LAST_ADDR);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    always_ff @(posedge host_wr or posedge clr) begin
      if (clr)
        words[g*DATA_W +: DATA_W] <= '0;
      else if (host_addr == ADDR_W'(g))
        words[g*DATA_W +: DATA_W] <= host_data;
    end
  end

  always_ff @(posedge host_wr or posedge clr) begin
    if (clr)
      wr_tgl <= 1'b0;
    else if (hit_any)
      wr_tgl <= ~wr_tgl;
  end
endmodule

// File: rtl/cfgw_sync.sv
// Toggle synchronizer with edge detect: one-cycle event per toggle flip.
module cfgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic evt
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst)
      chain[0] <= 1'b0;
    else
      chain[0] <= tgl_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        chain[s] <= 1'b0;
      else
        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_q <= 1'b0;
    else
      last_q <= chain[STAGES-1];
  end

  assign evt = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/cfgw_rst_timer.sv
// Down-counter that holds the datapath reset; reloads on each event.
module cfgw_rst_timer #(
  parameter int CYCLES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (start)
      cnt <= LOAD;
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_pkg::*;
#(
  parameter int RST_CYCLES  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CFG_W-1:0]  host_data,
  input  logic              host_wr,
  output logic              dp_reset,
  output logic [3:0]        decim_code,
  output logic              dual_mode,
  output logic              odd_sym,
  output logic              a_even_taps,
  output logic              b_even_taps,
  output logic              b_src_sel,
  output logic              interleave,
  output logic              a_in_fmt,
  output logic              a_coef_fmt,
  output logic              b_in_fmt,
  output logic              b_coef_fmt,
  output logic              reverse_en,
  output logic [3:0]        round_pos,
  output logic              round_en
);
  localparam int FLAT_W = NUM_REGS * CFG_W;

  logic [FLAT_W-1:0] host_words;
  logic              wr_tgl;
  logic              wr_evt;
  word0_t            w0_q;
  word1_t            w1_q;

  cfgw_capture #(.ADDR_W(ADDR_W), .DATA_W(CFG_W), .NUM_REGS(NUM_REGS)) u_cap (
    .host_wr  (host_wr),
    .clr      (rst),
    .host_addr(host_addr),
    .host_data(host_data),
    .words    (host_words),
    .wr_tgl   (wr_tgl)
  );

  cfgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .tgl_in(wr_tgl),
    .evt   (wr_evt)
  );

  cfgw_rst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (wr_evt),
    .active(dp_reset)
  );

  // Shadow copy in the clock domain; host words are stable by the event.
  always_ff @(posedge clk) begin
    if (rst) begin
      w0_q <= '0;
      w1_q <= '0;
    end else if (wr_evt) begin
      w0_q <= word0_t'(host_words[0 +: CFG_W]);
      w1_q <= word1_t'(host_words[CFG_W +: CFG_W]);
    end
  end

  assign decim_code  = w0_q.decim_code;
  assign dual_mode   = w0_q.dual_mode;
  assign odd_sym     = w0_q.odd_sym;
  assign a_even_taps = w0_q.a_even_taps;
  assign b_even_taps = w0_q.b_even_taps;
  assign b_src_sel   = w0_q.b_src_sel;
  assign interleave  = w0_q.interleave;
  assign a_in_fmt    = w1_q.a_in_fmt;
  assign a_coef_fmt  = w1_q.a_coef_fmt;
  assign b_in_fmt    = w1_q.b_in_fmt;
  assign b_coef_fmt  = w1_q.b_coef_fmt;
  assign reverse_en  = w1_q.reverse_en;
  assign round_pos   = w1_q.round_pos;
  assign round_en    = w1_q.round_en;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int RST_CYCLES = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_evt,
  input logic        dp_reset,
  input logic [19:0] fields
);
  localparam int HW = $clog2(RST_CYCLES + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || wr_evt)
      hi_cnt <= '0;
    else if (dp_reset)
      hi_cnt <= hi_cnt + HW'(1);
    else
      hi_cnt <= '0;
  end

  // R1: reset clears fields and the datapath reset
  p_clear_r1: assert property (@(posedge clk)
    rst |=> (!dp_reset && fields == '0));

  // R5: never longer than the configured length
  p_max_len_r5: assert property (@(posedge clk) disable iff (rst)
    dp_reset |-> (hi_cnt < HW'(RST_CYCLES)));

  // R5: a pulse not cut by rst ends at exactly the configured length
  p_full_len_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(dp_reset) && !$past(rst)) |-> (hi_cnt == HW'(RST_CYCLES)));

  // R6 and R7: each event raises or extends the reset
  p_evt_starts_r7: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> dp_reset);

  // R8: fields move only with an event
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(fields));
endmodule

bind cfg_port cfg_port_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_evt  (wr_evt),
  .dp_reset(dp_reset),
  .fields  ({round_en, round_pos, reverse_en, b_coef_fmt, b_in_fmt, a_coef_fmt, a_in_fmt,
             interleave, b_src_sel, b_even_taps, a_even_taps, odd_sym, dual_mode, decim_code})
);

// File: tb/tb_cfg_port.sv
module tb_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic [8:0] host_addr = '0;
  logic [9:0] host_data = '0;
  logic       dp_reset;
  logic [3:0] decim_code, round_pos;
  logic dual_mode, odd_sym, a_even_taps, b_even_taps, b_src_sel, interleave;
  logic a_in_fmt, a_coef_fmt, b_in_fmt, b_coef_fmt, reverse_en, round_en;

  cfg_port dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {addr, data, expected word0, expected word1}
  localparam logic [38:0] VEC [NVEC] = '{
    {9'h000, 10'h3FF, 10'h3FF, 10'h000},
    {9'h001, 10'h2A5, 10'h3FF, 10'h2A5},
    {9'h002, 10'h000, 10'h3FF, 10'h2A5},
    {9'h0FF, 10'h155, 10'h3FF, 10'h2A5},
    {9'h000, 10'h00F, 10'h00F, 10'h2A5},
    {9'h001, 10'h15A, 10'h00F, 10'h15A},
    {9'h100, 10'h3FF, 10'h00F, 10'h15A},
    {9'h000, 10'h230, 10'h230, 10'h15A}
  };

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic logic [9:0] get0();
    return {interleave, b_src_sel, b_even_taps, a_even_taps, odd_sym, dual_mode, decim_code};
  endfunction

  function automatic logic [9:0] get1();
    return {round_en, round_pos, reverse_en, b_coef_fmt, b_in_fmt, a_coef_fmt, a_in_fmt};
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Strobe rises on a falling edge (offset 0); samples at offsets 1..span.
  task automatic write_watch(input logic [8:0] a, input logic [9:0] d, input int span,
                             output int first, output int nhigh, output logic [19:0] early);
    @(negedge clk);
    host_addr = a; host_data = d; host_wr = 1'b1;
    first = 0; nhigh = 0; early = '0;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (i == 1) host_wr = 1'b0;
      if (i == 2) early = {get1(), get0()};
      if (dp_reset) begin
        nhigh++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int first, nhigh, last;
    logic [19:0] early, prev;
    repeat (3) @(negedge clk);
    check(get0() == 10'h0 && get1() == 10'h0 && !dp_reset, "R1 reset state",
          {get1(), get0(), dp_reset}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] a;
      logic [9:0] d, e0, e1;
      string tag;
      {a, d, e0, e1} = VEC[v];
      tag = (a == 9'h000) ? "R2" : (a == 9'h001) ? "R3" : "R4";
      prev = {get1(), get0()};
      write_watch(a, d, 12, first, nhigh, early);
      if (a < 9'd2) begin
        check(first == 3, "R6 reset start offset", first, 3);
        check(nhigh == 6, "R5 reset length", nhigh, 6);
      end else begin
        check(nhigh == 0, "R4 no reset on reserved write", nhigh, 0);
      end
      check(early == prev, "R8 fields held before load", early, prev);
      check(get0() == e0, {tag, " word0 fields"}, get0(), e0);
      check(get1() == e1, {tag, " word1 fields"}, get1(), e1);
    end

    // R7: second write five falling edges after the first
    @(negedge clk);
    host_addr = 9'h000; host_data = 10'h011; host_wr = 1'b1;
    first = 0; nhigh = 0; last = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (i == 1) host_wr = 1'b0;
      if (i == 4) check(get0() == 10'h011, "R7 first write fields", get0(), 10'h011);
      if (i == 5) begin host_data = 10'h022; host_wr = 1'b1; end
      if (i == 6) host_wr = 1'b0;
      if (dp_reset) begin
        nhigh++;
        last = i;
        if (first == 0) first = i;
      end
    end
    check(first == 3, "R7 restart first high", first, 3);
    check(last == 13, "R7 restart last high", last, 13);
    check(nhigh == 11, "R7 restart high count", nhigh, 11);
    check(get0() == 10'h022, "R7 second write fields", get0(), 10'h022);

    // R9: data changes while strobe held high are ignored
    @(negedge clk);
    host_addr = 9'h001; host_data = 10'h0C3; host_wr = 1'b1;
    @(negedge clk);
    host_data = 10'h3FF;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (10) @(negedge clk);
    check(get1() == 10'h0C3, "R9 data taken at rising edge", get1(), 10'h0C3);
    check(get0() == 10'h022, "R8 other word untouched", get0(), 10'h022);

    // R1: reset in the middle of an active datapath reset
    write_watch(9'h000, 10'h1E7, 4, first, nhigh, early);
    check(dp_reset == 1'b1, "R5 pulse active before reset", dp_reset, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!dp_reset && get0() == 10'h0 && get1() == 10'h0, "R1 mid-run reset",
          {get1(), get0(), dp_reset}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(!dp_reset && get0() == 10'h0, "R1 stays clear after reset",
          {get0(), dp_reset}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule